// File: doc/BRIEF.md
# Alternating Three-Sample Pattern Detector

This block watches a serial stream of single bits and raises a one-bit match flag in any sampled cycle where the newest three samples alternate, that is, the window is 0-1-0 or 1-0-1. The window includes the sample being presented in the current cycle, so the flag is a combinational (Mealy) function of the stored history and the live input bit. Windows overlap, which means that the bits that complete one hit can also begin the next one. In a stream such as 0-1-0-1-0, a hit is reported at each of the last three samples.

The two stored bits are kept in a four-state machine. The states are: a run of zeros (also the state after reset), a single one that follows a zero, a one followed by a zero, and a run of ones. Samples count only in cycles where the sample strobe is high. In all other cycles the history is held and the flag stays low. A small fill counter keeps the flag low until two samples are stored after reset. A parameter selects a binary or a one-hot encoding for the state register. The two encodings behave the same at the ports.

Top module: `alt3_detect`

## Requirements
- R1: While `rst` is high, `match` is 0. On the first clock edge with `rst` high, the stored history and the count of received samples are cleared.
- R2: When a sample is strobed whose value is 0, and the two samples strobed before it were 0 and then 1 (oldest first), `match` is 1 in that same cycle.
- R3: When a sample is strobed whose value is 1, and the two samples strobed before it were 1 and then 0 (oldest first), `match` is 1 in that same cycle.
- R4: Any other window of three strobed samples (000, 001, 011, 100, 110, 111, oldest first) gives `match` = 0.
- R5: Detection overlaps. After reset, the strobed input 0010101101000 (first bit first) produces `match` 0001111001100, one output per sample in the same cycle.
- R6: In a cycle where `smp_vld` is 0, `match` is 0 and `smp_bit` is ignored. The stored history is unchanged, so the next strobed sample is judged against the samples strobed before the gap.
- R7: `match` stays 0 for the first and second strobed samples after reset, whatever their values.
- R8: Both settings of `ONEHOT_STATE` (0 = two-bit binary state, 1 = four-bit one-hot state) give the same `match` sequence for the same stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | High in cycles that carry a sample |
| smp_bit | input | 1 | Serial data sample |
| match | output | 1 | High when the current sample completes 010 or 101 |

## Verification
The assertions assume that `rst` is high at time zero for at least one edge. They also assume that `smp_vld` and `smp_bit` are known and settled before each rising edge. The bench meets both assumptions by holding reset for several cycles and by changing inputs only on the falling edge. It toggles `smp_bit` during strobe gaps to show that the data bit has no effect there. It also applies a reset in the middle of a stream after two samples, so that a stale history would give a false hit on the next sample. Both state encodings run side by side against one reference model.

// File: rtl/alt3_pkg.sv
package alt3_pkg;

   // number of samples in the detection window
   localparam int unsigned WIN_LEN = 3;
   // samples that must be stored before a window is complete
   localparam int unsigned HIST_LEN = WIN_LEN - 1;

   // bit 0 holds the newest stored sample, bit 1 the one before it
   typedef enum logic [1:0] {
      ST_ZERO = 2'b00,   // run of zeros, also the reset state
      ST_ONE  = 2'b01,   // a single 1 after a 0
      ST_TEN  = 2'b10,   // a 1 then a 0
      ST_ONES = 2'b11    // run of ones
   } alt_st_e;

   function automatic alt_st_e alt_step(alt_st_e s, logic b);
      alt_st_e n;
      case (s)
         ST_ZERO: n = b ? ST_ONE  : ST_ZERO;
         ST_ONE:  n = b ? ST_ONES : ST_TEN;
         ST_TEN:  n = b ? ST_ONE  : ST_ZERO;
         default: n = b ? ST_ONES : ST_TEN;
      endcase
      return n;
   endfunction

   function automatic logic alt_hit(alt_st_e s, logic b);
      return ((s == ST_ONE) && !b) || ((s == ST_TEN) && b);
   endfunction

endpackage

// File: rtl/alt3_fill_cnt.sv
module alt3_fill_cnt #(
   parameter int unsigned NEED = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic adv,
   output logic primed
);
   localparam int unsigned CW = $clog2(NEED + 1);
   localparam logic [CW-1:0] FULL = CW'(NEED);

   if (NEED < 1) begin : g_bad_need
      $error("alt3_fill_cnt: NEED must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (adv && (cnt_q != FULL))
         cnt_q <= cnt_q + 1'b1;
   end

   assign primed = (cnt_q == FULL);

   // R7: counter saturates at the fill level
   p_fill_range_r7: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= FULL);

   // R6: no strobe, no count change
   p_fill_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(cnt_q));

endmodule

// File: rtl/alt3_state_reg.sv
module alt3_state_reg
   import alt3_pkg::*;
#(
   parameter bit ONEHOT_STATE = 1'b0
) (
   input  logic    clk,
   input  logic    rst,
   input  logic    adv,
   input  logic    bit_in,
   output alt_st_e st
);

   if (ONEHOT_STATE) begin : g_onehot
      logic [3:0] oh_q;
      alt_st_e    cur;
      alt_st_e    nxt;

      always_comb begin
         unique case (1'b1)
            oh_q[1]: cur = ST_ONE;
            oh_q[2]: cur = ST_TEN;
            oh_q[3]: cur = ST_ONES;
            default: cur = ST_ZERO;
         endcase
      end

      assign nxt = alt_step(cur, bit_in);

      always_ff @(posedge clk) begin
         if (rst)
            oh_q <= 4'b0001;
         else if (adv)
            oh_q <= 4'b0001 << nxt;
      end

      assign st = cur;

      // R8: one-hot register keeps exactly one bit set
      p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
         $onehot(oh_q));
   end else begin : g_binary
      alt_st_e st_q;

      always_ff @(posedge clk) begin
         if (rst)
            st_q <= ST_ZERO;
         else if (adv)
            st_q <= alt_step(st_q, bit_in);
      end

      assign st = st_q;
   end

   // R6: history frozen while no sample is strobed
   p_state_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(st));

   // R1: reset lands in the run-of-zeros state
   p_reset_state_r1: assert property (@(posedge clk)
      rst |=> (st == ST_ZERO));

endmodule

// File: rtl/alt3_match_dec.sv
module alt3_match_dec
   import alt3_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  logic    vld,
   input  logic    bit_in,
   input  logic    primed,
   input  alt_st_e st,
   output logic    match
);

   assign match = !rst && vld && primed && alt_hit(st, bit_in);

   // R6: idle cycles never flag
   p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
      !vld |-> !match);

   // R1: flag low during reset
   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |-> !match);

endmodule

// File: rtl/alt3_detect.sv
module alt3_detect
   import alt3_pkg::*;
#(
   parameter bit ONEHOT_STATE = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic smp_vld,
   input  logic smp_bit,
   output logic match
);

   alt_st_e st;
   logic    primed;

   alt3_state_reg #(
      .ONEHOT_STATE(ONEHOT_STATE)
   ) u_state (
      .clk   (clk),
      .rst   (rst),
      .adv   (smp_vld),
      .bit_in(smp_bit),
      .st    (st)
   );

   alt3_fill_cnt #(
      .NEED(HIST_LEN)
   ) u_fill (
      .clk   (clk),
      .rst   (rst),
      .adv   (smp_vld),
      .primed(primed)
   );

   alt3_match_dec u_dec (
      .clk   (clk),
      .rst   (rst),
      .vld   (smp_vld),
      .bit_in(smp_bit),
      .primed(primed),
      .st    (st),
      .match (match)
   );

   // R5: newest stored bit is the last strobed sample
   p_last_bit_r5: assert property (@(posedge clk) disable iff (rst)
      smp_vld |=> (st[0] == $past(smp_bit)));

   // R2 and R3: a hit implies the three bits alternate
   p_alt_r3: assert property (@(posedge clk) disable iff (rst)
      match |-> ((smp_bit != st[0]) && (st[1] != st[0])));

endmodule

// File: tb/alt3_detect_tb.sv
module alt3_detect_tb;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic  exp;
      string tag;
   } item_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic smp_vld = 1'b0;
   logic smp_bit = 1'b0;
   logic match_bin;
   logic match_oh;

   int total = 0;
   int bad = 0;
   item_t sb_q[$];

   // reference history
   logic [1:0] m_hist = 2'b00;
   int         m_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alt3_detect #(.ONEHOT_STATE(1'b0)) u_dut (
      .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_bit(smp_bit),
      .match(match_bin)
   );

   alt3_detect #(.ONEHOT_STATE(1'b1)) u_dut_oh (
      .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_bit(smp_bit),
      .match(match_oh)
   );

   task automatic drive(input logic r, input logic v, input logic b,
                        input string tag);
      item_t it;
      @(negedge clk);
      rst = r;
      smp_vld = v;
      smp_bit = b;
      if (r)
         it.exp = 1'b0;
      else if (v)
         it.exp = (m_cnt >= 2) && (m_hist[1] != m_hist[0]) && (m_hist[0] != b);
      else
         it.exp = 1'b0;
      it.tag = tag;
      sb_q.push_back(it);
      if (r) begin
         m_hist = 2'b00;
         m_cnt = 0;
      end else if (v) begin
         m_hist = {m_hist[0], b};
         if (m_cnt < 2) m_cnt++;
      end
   endtask

   task automatic feed(input string bits, input string tag);
      for (int i = 0; i < bits.len(); i++)
         drive(1'b0, 1'b1, bits[i] == "1", tag);
   endtask

   // monitor: compare a quarter period after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_PERIOD/4);
         if (sb_q.size() != 0) begin
            item_t it;
            it = sb_q.pop_front();
            total++;
            if (match_bin !== it.exp) begin
               bad++;
               $display("FAIL %s binary: match=%b expected=%b", it.tag, match_bin, it.exp);
            end
            total++;
            if (match_oh !== it.exp) begin
               bad++;
               $display("FAIL %s R8 one-hot: match=%b expected=%b", it.tag, match_oh, it.exp);
            end
         end
      end
   end

   // stated sequence check with explicit expected string (R5)
   task automatic r5_stated();
      string ins = "0010101101000";
      string outs = "0001111001100";
      for (int i = 0; i < ins.len(); i++) begin
         drive(1'b0, 1'b1, ins[i] == "1", "R5");
         #(CLK_PERIOD/4);
         total++;
         if (match_bin !== (outs[i] == "1")) begin
            bad++;
            $display("FAIL R5 step %0d: match=%b expected=%c", i, match_bin, outs[i]);
         end
      end
   endtask

   initial begin
      // R1: reset cycles
      for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 1'b0, "R1");
      drive(1'b1, 1'b1, 1'b1, "R1");
      // R7: first two samples never flag, third can (R3 101)
      feed("10", "R7");
      feed("1", "R3");
      // R2: 010
      drive(1'b1, 1'b0, 1'b0, "R1");
      feed("010", "R2");
      // R5: stated overlap sequence
      drive(1'b1, 1'b0, 1'b0, "R1");
      r5_stated();
      // R6: gap with toggling data, history kept
      drive(1'b1, 1'b0, 1'b0, "R1");
      feed("01", "R6");
      drive(1'b0, 1'b0, 1'b1, "R6");
      drive(1'b0, 1'b0, 1'b0, "R6");
      drive(1'b0, 1'b0, 1'b1, "R6");
      feed("0", "R6");
      drive(1'b0, 1'b0, 1'b0, "R6");
      feed("1", "R6");
      // R4: non-alternating windows
      feed("1100011100", "R4");
      // R7: reset mid-stream clears history
      feed("10", "R7");
      drive(1'b1, 1'b0, 1'b0, "R1");
      feed("1", "R7");
      feed("0", "R7");
      feed("1", "R3");
      feed("0101", "R5");
      drive(1'b0, 1'b0, 1'b0, "R6");
      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   // watchdog
   initial begin
      #(CLK_PERIOD * 20000);
      bad++;
      $display("FAIL watchdog expired: cycles=%0d expected below=%0d", 20000, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule